// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block holds a small bank of hardware debug triggers for a processor core. In every cycle the core can present one memory access: an instruction fetch, a load or a store, with its address or data value and the privilege level it runs at. The unit tests that access against every trigger and reports whether one fired. If one fired, it also reports that trigger's index and the action code stored in it. The core acts on the result. It may take a breakpoint exception, enter debug mode or drive trace. None of those actions are part of this block.

Each trigger has a control word and a compare word. Both are reached through one register port, and a select register picks the trigger. The control word chooses which operations and which privilege levels the trigger watches, and which of six compare modes it uses. Its chain bit links it to the next trigger, so that a group of neighbours fires only when every member matches. The result is registered and appears one cycle after the access.

Top module: `trig_match_unit`

## Requirements
- R1: Control word layout, with XLEN = 32. Bits 31:28 are a type field that always reads 2. Bit 27 is a writable debug-only flag. Bits 26:21 are a read-only maximum-mask field that reads the MASKMAX parameter. Bits 20:0 are writable except bit 20, which reads 0: select (19), timing (18), action (17:12), chain (11), match (10:7), privilege enables machine/hypervisor/supervisor/user at 6/5/4/3, execute (2), store (1), load (0). Writes to bits 31:28 and 26:20 have no effect.
- R2: The select register, written with `sel_wr_data`, chooses the trigger that the control and compare ports read and write. With a select value of NTRIG or more, both reads return zero and writes change no trigger.
- R3: After reset every trigger's writable control bits and its compare word are zero. Such a trigger watches no operation, so no access produces a hit.
- R4: Operation codes are 0 fetch, 1 load, 2 store and 3 idle. A trigger takes part only when its enable bit for the access's operation is set: execute for a fetch, load for a load, store for a store. Code 3 never matches.
- R5: A trigger takes part only when the enable bit for `acc_priv` is set. Privilege 0 selects bit 3, 1 selects bit 4, 2 selects bit 5 and 3 selects bit 6.
- R6: Match code 0 requires the value to equal the compare word. Code 1 (NAPOT) counts the trailing one bits of the compare word, ignores that many low bits on both sides and compares the rest. All ones ignores every bit.
- R7: Match code 2 hits when value >= compare, and code 3 hits when value < compare. Both comparisons are unsigned. Codes 6 to 15 never hit.
- R8: Match codes 4 and 5 use compare bits 31:16 as a mask. Code 4 hits when the value's bits 15:0 equal compare bits 15:0 in every masked position. Code 5 does the same with value bits 31:16 in place of the low half.
- R9: A matching trigger with the chain bit set fires nothing by itself. It lets the next trigger be evaluated. A chain fires only when all members match. The hit then reports the index and action of the chain's last member, which is the first one with the chain bit clear.
- R10: A trigger that fails inside a chain suppresses every later member of that chain. Evaluation starts afresh with the trigger after the chain's last member.
- R11: When several independent triggers or chains would fire, the lowest index wins.
- R12: `hit_valid` rises only in the cycle after an access with `acc_valid` high and `cause_pending` low. Whenever `hit_valid` is low, `hit_index` and `hit_action` are zero.
- R13: An access is judged against the trigger settings held before any register write in the same cycle. The write affects accesses from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr_en | input | 1 | Write strobe for the select register |
| sel_wr_data | input | SELW | New select value |
| cfg_wr_en | input | 1 | Write strobe for the selected trigger's control word |
| cfg_wr_data | input | XLEN | Control word write data |
| cmp_wr_en | input | 1 | Write strobe for the selected trigger's compare word |
| cmp_wr_data | input | XLEN | Compare word write data |
| cfg_rd_data | output | XLEN | Selected control word, zero if the select is out of range |
| cmp_rd_data | output | XLEN | Selected compare word, zero if the select is out of range |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_op | input | 2 | Operation: 0 fetch, 1 load, 2 store, 3 idle |
| acc_priv | input | 2 | Privilege level, 0 to 3 |
| acc_value | input | XLEN | Address or data value of the access |
| cause_pending | input | 1 | A debug cause is already pending; blocks all hits |
| hit_valid | output | 1 | A trigger fired on the previous cycle's access |
| hit_index | output | IDXW | Index of the firing trigger |
| hit_action | output | 6 | Action code of the firing trigger |

## Verification
Two functions can act in the same cycle: a register write to the selected trigger, and an access that this trigger would match. The bench presents an access together with a compare-word write to the same trigger, and expects the hit to follow the old compare value. It then sends the old and the new values again and expects the hit to follow the new one. All other checks use a bench model written from the requirements. That model drives sweeps over every operation, privilege and enable combination, over all six compare modes at edge values, and over all 256 combinations of four chain bits and four per-trigger match outcomes.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
    // low control-word field positions (decoded by the compare logic)
    localparam int F_LOAD     = 0;
    localparam int F_STORE    = 1;
    localparam int F_EXEC     = 2;
    localparam int F_CHAIN    = 11;
    localparam int F_ACT_LO   = 12;
    localparam int LOW_W      = 20;   // bits 19:0 writable
    localparam int CTL_LO_W   = 18;   // bits 17:0 seen by match logic
    localparam int ACT_W      = 6;
    localparam logic [3:0] TRIG_TYPE_VAL = 4'd2;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_IDLE  = 2'd3
    } acc_op_e;

    typedef enum logic [3:0] {
        MT_EQ      = 4'd0,
        MT_NAPOT   = 4'd1,
        MT_GE      = 4'd2,
        MT_LT      = 4'd3,
        MT_MASK_LO = 4'd4,
        MT_MASK_HI = 4'd5
    } match_e;
endpackage

// File: rtl/trig_regfile.sv
`timescale 1ns/1ps
module trig_regfile
    import trig_pkg::*;
#(
    parameter int NTRIG   = 4,
    parameter int XLEN    = 32,
    parameter int SELW    = 3,
    parameter int MASKMAX = 31,
    localparam int IDXW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel_wr_en,
    input  logic [SELW-1:0]                   sel_wr_data,
    input  logic                              cfg_wr_en,
    input  logic [XLEN-1:0]                   cfg_wr_data,
    input  logic                              cmp_wr_en,
    input  logic [XLEN-1:0]                   cmp_wr_data,
    output logic [XLEN-1:0]                   cfg_rd_data,
    output logic [XLEN-1:0]                   cmp_rd_data,
    output logic [NTRIG-1:0][CTL_LO_W-1:0]    ctl_lo,
    output logic [NTRIG-1:0][XLEN-1:0]        cmp_all
);
    localparam logic [XLEN-1:0] WR_MASK  = (XLEN'(1) << (XLEN-5)) | XLEN'((1 << LOW_W) - 1);
    localparam logic [XLEN-1:0] FIX_BITS = (XLEN'(TRIG_TYPE_VAL) << (XLEN-4))
                                         | (XLEN'(MASKMAX & 63) << (XLEN-11));

    typedef struct packed {
        logic [SELW-1:0]                sel;
        logic [NTRIG-1:0][XLEN-1:0]     cfg;
        logic [NTRIG-1:0][XLEN-1:0]     cmp;
    } rf_t;

    rf_t rf_d, rf_q;
    logic sel_ok;

    always_comb begin
        rf_d = rf_q;
        if (sel_wr_en) begin
            rf_d.sel = sel_wr_data;
        end
        for (int i = 0; i < NTRIG; i++) begin
            if (rf_q.sel == SELW'(i)) begin
                if (cfg_wr_en) begin
                    rf_d.cfg[i] = cfg_wr_data & WR_MASK;
                end
                if (cmp_wr_en) begin
                    rf_d.cmp[i] = cmp_wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        sel_ok      = (int'(rf_q.sel) < NTRIG);
        cfg_rd_data = '0;
        cmp_rd_data = '0;
        if (sel_ok) begin
            cfg_rd_data = rf_q.cfg[rf_q.sel[IDXW-1:0]] | FIX_BITS;
            cmp_rd_data = rf_q.cmp[rf_q.sel[IDXW-1:0]];
        end
    end

    for (genvar g = 0; g < NTRIG; g++) begin : g_view
        assign ctl_lo[g]  = rf_q.cfg[g][CTL_LO_W-1:0];
        assign cmp_all[g] = rf_q.cmp[g];
    end
endmodule

// File: rtl/trig_cmp.sv
`timescale 1ns/1ps
module trig_cmp
    import trig_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [10:0]     ctl,
    input  logic [XLEN-1:0] cmp,
    input  logic [1:0]      op,
    input  logic [1:0]      priv,
    input  logic [XLEN-1:0] value,
    output logic            hit
);
    localparam int HALF = XLEN / 2;

    logic            op_en;
    logic            priv_en;
    logic            val_hit;
    logic [3:0]      priv_bits;
    logic [XLEN-1:0] napot_keep;
    logic [HALF-1:0] half_mask;

    always_comb begin
        unique case (acc_op_e'(op))
            OP_FETCH: op_en = ctl[F_EXEC];
            OP_LOAD:  op_en = ctl[F_LOAD];
            OP_STORE: op_en = ctl[F_STORE];
            default:  op_en = 1'b0;
        endcase
        priv_bits = ctl[6:3];
        priv_en   = priv_bits[priv];
    end

    // a bit is kept unless it and all bits below it are one in cmp
    always_comb begin : napot_p
        logic run;
        run = 1'b1;
        for (int j = 0; j < XLEN; j++) begin
            run           = run & cmp[j];
            napot_keep[j] = ~run;
        end
    end

    always_comb begin
        half_mask = cmp[XLEN-1:HALF];
        case (match_e'(ctl[10:7]))
            MT_EQ:      val_hit = (value == cmp);
            MT_NAPOT:   val_hit = (((value ^ cmp) & napot_keep) == '0);
            MT_GE:      val_hit = (value >= cmp);
            MT_LT:      val_hit = (value < cmp);
            MT_MASK_LO: val_hit = (((value[HALF-1:0] ^ cmp[HALF-1:0]) & half_mask) == '0);
            MT_MASK_HI: val_hit = (((value[XLEN-1:HALF] ^ cmp[HALF-1:0]) & half_mask) == '0);
            default:    val_hit = 1'b0;
        endcase
        hit = op_en & priv_en & val_hit;
    end
endmodule

// File: rtl/trig_resolve.sv
`timescale 1ns/1ps
module trig_resolve
    import trig_pkg::*;
#(
    parameter int NTRIG = 4,
    localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic [NTRIG-1:0]            hit,
    input  logic [NTRIG-1:0]            chain,
    input  logic [NTRIG-1:0][ACT_W-1:0] action,
    output logic                        fire,
    output logic [IDXW-1:0]             idx,
    output logic [ACT_W-1:0]            act
);
    always_comb begin : scan_p
        logic broken;
        fire   = 1'b0;
        idx    = '0;
        act    = '0;
        broken = 1'b0;
        for (int i = 0; i < NTRIG; i++) begin
            if (!fire) begin
                if (broken) begin
                    if (!chain[i]) begin
                        broken = 1'b0;   // chain ends here, next starts fresh
                    end
                end else if (hit[i]) begin
                    if (!chain[i]) begin
                        fire = 1'b1;
                        idx  = IDXW'(i);
                        act  = action[i];
                    end
                end else if (chain[i]) begin
                    broken = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/trig_match_unit.sv
`timescale 1ns/1ps
module trig_match_unit
    import trig_pkg::*;
#(
    parameter int NTRIG   = 4,
    parameter int XLEN    = 32,
    parameter int SELW    = 3,
    parameter int MASKMAX = 31,
    localparam int IDXW   = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr_en,
    input  logic [SELW-1:0]  sel_wr_data,
    input  logic             cfg_wr_en,
    input  logic [XLEN-1:0]  cfg_wr_data,
    input  logic             cmp_wr_en,
    input  logic [XLEN-1:0]  cmp_wr_data,
    output logic [XLEN-1:0]  cfg_rd_data,
    output logic [XLEN-1:0]  cmp_rd_data,
    input  logic             acc_valid,
    input  logic [1:0]       acc_op,
    input  logic [1:0]       acc_priv,
    input  logic [XLEN-1:0]  acc_value,
    input  logic             cause_pending,
    output logic             hit_valid,
    output logic [IDXW-1:0]  hit_index,
    output logic [5:0]       hit_action
);
    typedef struct packed {
        logic             valid;
        logic [IDXW-1:0]  index;
        logic [ACT_W-1:0] action;
    } res_t;

    logic [NTRIG-1:0][CTL_LO_W-1:0] ctl_lo;
    logic [NTRIG-1:0][XLEN-1:0]     cmp_all;
    logic [NTRIG-1:0]               raw_hit;
    logic [NTRIG-1:0]               chain_bits;
    logic [NTRIG-1:0][ACT_W-1:0]    act_bits;
    logic                           fire;
    logic [IDXW-1:0]                fire_idx;
    logic [ACT_W-1:0]               fire_act;
    res_t                           res_d, res_q;

    trig_regfile #(
        .NTRIG(NTRIG), .XLEN(XLEN), .SELW(SELW), .MASKMAX(MASKMAX)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .cfg_rd_data(cfg_rd_data), .cmp_rd_data(cmp_rd_data),
        .ctl_lo(ctl_lo), .cmp_all(cmp_all)
    );

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        assign chain_bits[g] = ctl_lo[g][F_CHAIN];
        assign act_bits[g]   = ctl_lo[g][F_ACT_LO +: ACT_W];
        trig_cmp #(.XLEN(XLEN)) cmp_i (
            .ctl(ctl_lo[g][10:0]), .cmp(cmp_all[g]),
            .op(acc_op), .priv(acc_priv), .value(acc_value),
            .hit(raw_hit[g])
        );
    end

    trig_resolve #(.NTRIG(NTRIG)) res_i (
        .hit(raw_hit), .chain(chain_bits), .action(act_bits),
        .fire(fire), .idx(fire_idx), .act(fire_act)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = acc_valid & ~cause_pending & fire;
        if (res_d.valid) begin
            res_d.index  = fire_idx;
            res_d.action = fire_act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_valid  = res_q.valid;
    assign hit_index  = res_q.index;
    assign hit_action = res_q.action;
endmodule

// File: rtl/trig_match_chk.sv
`timescale 1ns/1ps
module trig_match_chk #(
    parameter int NTRIG = 4,
    parameter int XLEN  = 32,
    localparam int IDXW = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sel_wr_en,
    input logic            cfg_wr_en,
    input logic            cmp_wr_en,
    input logic [XLEN-1:0] cfg_rd_data,
    input logic            acc_valid,
    input logic            cause_pending,
    input logic            hit_valid,
    input logic [IDXW-1:0] hit_index,
    input logic [5:0]      hit_action
);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !hit_valid);

    p_pending_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cause_pending |=> !hit_valid);

    p_quiet_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> (hit_index == '0 && hit_action == '0));

    p_type_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data != '0) |-> (cfg_rd_data[XLEN-1 -: 4] == 4'd2));

    p_cmp_wr_cfg_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_en && !cfg_wr_en && !sel_wr_en) |=> $stable(cfg_rd_data));
endmodule

bind trig_match_unit trig_match_chk #(.NTRIG(NTRIG), .XLEN(XLEN)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .sel_wr_en(sel_wr_en), .cfg_wr_en(cfg_wr_en), .cmp_wr_en(cmp_wr_en),
    .cfg_rd_data(cfg_rd_data),
    .acc_valid(acc_valid), .cause_pending(cause_pending),
    .hit_valid(hit_valid), .hit_index(hit_index), .hit_action(hit_action)
);

// File: tb/trig_match_unit_tb_top.sv
`timescale 1ns/1ps
module trig_match_unit_tb_top;
    localparam int NT = 4;
    localparam int XL = 32;
    localparam int SW = 3;
    localparam int MM = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr_en = 1'b0;
    logic [2:0]  sel_wr_data = '0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        cmp_wr_en = 1'b0;
    logic [31:0] cmp_wr_data = '0;
    logic [31:0] cfg_rd_data, cmp_rd_data;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_op = '0;
    logic [1:0]  acc_priv = '0;
    logic [31:0] acc_value = '0;
    logic        cause_pending = 1'b0;
    logic        hit_valid;
    logic [1:0]  hit_index;
    logic [5:0]  hit_action;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] bcfg [NT];
    logic [31:0] bcmp [NT];

    always #2 clk = ~clk;

    trig_match_unit #(.NTRIG(NT), .XLEN(XL), .SELW(SW), .MASKMAX(MM)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .cfg_rd_data(cfg_rd_data), .cmp_rd_data(cmp_rd_data),
        .acc_valid(acc_valid), .acc_op(acc_op), .acc_priv(acc_priv),
        .acc_value(acc_value), .cause_pending(cause_pending),
        .hit_valid(hit_valid), .hit_index(hit_index), .hit_action(hit_action)
    );

    localparam logic [31:0] FIXED = (32'd2 << 28) | (32'(MM) << 21);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkcfg(int act, int ch, int mt, int pm, int om);
        return (32'(act) << 12) | (32'(ch) << 11) | (32'(mt) << 7) | (32'(pm) << 3) | 32'(om);
    endfunction

    function automatic bit ref_one(logic [31:0] c, logic [31:0] k, int op, int pv, logic [31:0] v);
        bit en_op, m;
        int t;
        logic [31:0] msk;
        case (op)
            0: en_op = c[2];
            1: en_op = c[0];
            2: en_op = c[1];
            default: en_op = 0;
        endcase
        if (!en_op || !c[3 + pv]) return 0;
        msk = k >> 16;
        case (int'(c[10:7]))
            0: m = (v == k);
            1: begin
                t = 0;
                while (t < 32 && k[t]) t++;
                m = (t >= 32) ? 1'b1 : ((v >> t) == (k >> t));
            end
            2: m = (v >= k);
            3: m = (v < k);
            4: m = ((v & msk) == (k & msk));
            5: m = (((v >> 16) & msk) == (k & msk));
            default: m = 0;
        endcase
        return m;
    endfunction

    // {valid, index[1:0], action[5:0]}
    function automatic logic [8:0] ref_hit(int op, int pv, logic [31:0] v, bit pend);
        bit broken = 0;
        bit h, ch;
        if (pend) return '0;
        for (int i = 0; i < NT; i++) begin
            h  = ref_one(bcfg[i], bcmp[i], op, pv, v);
            ch = bcfg[i][11];
            if (broken) begin
                if (!ch) broken = 0;
            end else if (h) begin
                if (!ch) return {1'b1, 2'(i), bcfg[i][17:12]};
            end else if (ch) begin
                broken = 1;
            end
        end
        return '0;
    endfunction

    task automatic wr_sel(int s);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = 3'(s);
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    task automatic write_trig(int i, logic [31:0] c, logic [31:0] k);
        wr_sel(i);
        cfg_wr_en = 1'b1; cfg_wr_data = c;
        cmp_wr_en = 1'b1; cmp_wr_data = k;
        @(negedge clk);
        cfg_wr_en = 1'b0; cmp_wr_en = 1'b0;
        bcfg[i] = c & 32'h080F_FFFF;
        bcmp[i] = k;
    endtask

    task automatic access(string tag, int op, int pv, logic [31:0] v, bit pend);
        logic [8:0] exp;
        exp = ref_hit(op, pv, v, pend);
        @(negedge clk);
        acc_valid = 1'b1; acc_op = 2'(op); acc_priv = 2'(pv);
        acc_value = v; cause_pending = pend;
        @(negedge clk);
        acc_valid = 1'b0; cause_pending = 1'b0;
        check(tag, {55'd0, hit_valid, hit_index, hit_action}, {55'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf, kv, vv;
        logic [31:0] cmps [6][3];
        for (int i = 0; i < NT; i++) begin bcfg[i] = '0; bcmp[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state; R2 out-of-range select reads zero
        check("R3 hit after reset", {63'd0, hit_valid}, 64'd0);
        for (int s = 0; s < 8; s++) begin
            wr_sel(s);
            check("R3 R2 cfg read", {32'd0, cfg_rd_data}, {32'd0, (s < NT) ? FIXED : 32'd0});
            check("R3 R2 cmp read", {32'd0, cmp_rd_data}, 64'd0);
        end
        for (int op = 0; op < 4; op++)
            access("R3 no hit when unused", op, 3, 32'd0, 0);

        // R1 field layout: write all ones, type and maskmax stay fixed
        write_trig(0, 32'hFFFF_FFFF, 32'h5A5A_0001);
        check("R1 all-ones readback", {32'd0, cfg_rd_data}, {32'd0, FIXED | (32'd1 << 27) | 32'h000F_FFFF});
        check("R1 compare readback", {32'd0, cmp_rd_data}, {32'd0, 32'h5A5A_0001});
        write_trig(0, 32'h0000_0000, 32'd0);
        check("R1 cleared readback", {32'd0, cfg_rd_data}, {32'd0, FIXED});

        // R2 write with select beyond range touches no trigger
        wr_sel(6);
        cfg_wr_en = 1'b1; cfg_wr_data = 32'h000F_FFFF;
        cmp_wr_en = 1'b1; cmp_wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cfg_wr_en = 1'b0; cmp_wr_en = 1'b0;
        check("R2 out-of-range cfg read", {32'd0, cfg_rd_data}, 64'd0);
        for (int s = 0; s < NT; s++) begin
            wr_sel(s);
            check("R2 cfg untouched", {32'd0, cfg_rd_data}, {32'd0, FIXED});
            check("R2 cmp untouched", {32'd0, cmp_rd_data}, 64'd0);
        end

        // R4 R5 operation and privilege filtering sweep
        for (int eo = 0; eo < 8; eo++) begin
            for (int ep = 0; ep < 16; ep++) begin
                write_trig(1, mkcfg(ep, 0, 0, ep, eo), 32'h0000_1234);
                for (int op = 0; op < 4; op++)
                    for (int pv = 0; pv < 4; pv++)
                        access("R4 R5 filter", op, pv, 32'h0000_1234, 0);
            end
        end
        write_trig(1, 32'd0, 32'd0);

        // R6 R7 R8 compare modes
        cmps[0] = '{32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF};
        cmps[1] = '{32'h4000_00FF, 32'hFFFF_FFFF, 32'h8000_0000};
        cmps[2] = '{32'h8000_0000, 32'h0000_0000, 32'h0000_1000};
        cmps[3] = '{32'h8000_0000, 32'h0000_0000, 32'h0000_1000};
        cmps[4] = '{32'h00F0_1234, 32'hFFFF_ABCD, 32'h0000_5555};
        cmps[5] = '{32'h0F0F_1234, 32'hFFFF_8001, 32'h0000_0000};
        lf = 32'h1ACE_B00C;
        for (int md = 0; md < 8; md++) begin
            for (int ci = 0; ci < 3; ci++) begin
                kv = cmps[md % 6][ci];
                write_trig(2, mkcfg(md + 1, 0, md, 4'hF, 3'b111), kv);
                for (int vi = 0; vi < 16; vi++) begin
                    case (vi)
                        0: vv = kv;
                        1: vv = kv ^ 32'h1;
                        2: vv = kv ^ 32'h100;
                        3: vv = kv ^ 32'h8000_0000;
                        4: vv = kv ^ 32'h0001_0000;
                        5: vv = kv + 32'd1;
                        6: vv = kv - 32'd1;
                        7: vv = 32'd0;
                        8: vv = 32'hFFFF_FFFF;
                        9: vv = {kv[15:0], kv[15:0]};
                        default: begin
                            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                            vv = (vi[0]) ? lf : (kv ^ (lf & 32'h0000_00FF));
                        end
                    endcase
                    access(md < 2 ? "R6 equal/napot" : (md < 4 ? "R7 ge/lt" : (md < 6 ? "R8 half mask" : "R7 unused code")),
                           0, 3, vv, 0);
                end
            end
        end
        write_trig(2, 32'd0, 32'd0);

        // R9 R10 R11 chains and priority: all chain and match patterns
        for (int cp = 0; cp < 16; cp++) begin
            for (int hp = 0; hp < 16; hp++) begin
                for (int i = 0; i < NT; i++)
                    write_trig(i, mkcfg(i + 1, cp[i], 0, 4'hF, 3'b111),
                               hp[i] ? 32'hCAFE_0042 : 32'h0000_0042);
                access("R9 R10 R11 chain sweep", 0, 3, 32'hCAFE_0042, 0);
            end
        end

        // R12 pending cause blocks, idle cycle quiet
        for (int i = 0; i < NT; i++) write_trig(i, 32'd0, 32'd0);
        write_trig(0, mkcfg(1, 0, 0, 4'hF, 3'b111), 32'h0000_0A0A);
        access("R12 pending blocks", 0, 3, 32'h0000_0A0A, 1);
        access("R12 hit without pending", 0, 3, 32'h0000_0A0A, 0);
        @(negedge clk);
        check("R12 quiet when no access", {54'd0, hit_valid, hit_index, hit_action}, 64'd0);

        // R13 write and access in the same cycle: old settings apply
        @(negedge clk);
        acc_valid = 1'b1; acc_op = 2'd0; acc_priv = 2'd3; acc_value = 32'h0000_0A0A;
        cmp_wr_en = 1'b1; cmp_wr_data = 32'h0000_0B0B;
        @(negedge clk);
        acc_valid = 1'b0; cmp_wr_en = 1'b0;
        check("R13 old compare used", {55'd0, hit_valid, hit_index, hit_action}, {55'd0, 1'b1, 2'd0, 6'd1});
        bcmp[0] = 32'h0000_0B0B;
        access("R13 old value after write", 0, 3, 32'h0000_0A0A, 0);
        access("R13 new value after write", 0, 3, 32'h0000_0B0B, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule